// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns stereo PCM arriving on up to three serial data lines into parallel 24-bit two's-complement words. All lines share one bit clock and one frame clock. Both clocks arrive already synchronized into the system clock domain, and the block samples them there. A rising bit-clock edge is found by comparing the bit clock with its value one system clock earlier. On that edge the block samples the frame clock and every data line.

A 3-bit format select picks one of five framings:

| Code | Framing |
|------|---------|
| 0 | 16-bit right-justified |
| 1 | 20-bit right-justified |
| 2 | 24-bit left-justified (reset default of the sender) |
| 3 | 24-bit I2S |
| 4 | 24-bit right-justified |

One shared control engine serves all five framings. For I2S it delays the frame clock by one bit clock, and from then on treats the stream as left-justified with the opposite channel polarity.

When a left half frame and the following right half frame have both arrived with enough bits, all six words are published together. The block raises a one-cycle valid strobe at the same time. Frames whose halves are too short are discarded without a strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 0 takes the last 16 bit slots of each half frame as the word, MSB first. It outputs the word in the upper 16 bits of the 24-bit result, with the low 8 bits zero.
- R2: Format code 1 takes the last 20 bit slots of each half frame, MSB first. It outputs them in the upper 20 bits, with the low 4 bits zero.
- R3: Format code 2 takes the first 24 slots after the frame-clock edge, MSB first. A 16-bit word padded with zero LSBs by the sender comes out unchanged.
- R4: Format code 3 (I2S) takes 24 bits starting one bit clock after the frame-clock edge, MSB first. The left channel is the half with the frame clock low, and the LSB may fall in the first slot of the following half.
- R5: Format code 4 takes the last 24 slots of each half frame as the word, MSB first.
- R6: In the right-justified formats, slots before the word carry no weight. Random content there never changes the output.
- R7: In codes 0, 1, 2 and 4, the half with the frame clock high is the left channel. The left word is the one that precedes the right word of the same frame.
- R8: A frame publishes all left and right words of every line at once. The frame-valid strobe is high for exactly one system clock per published frame, and the outputs hold their values between strobes.
- R9: The bit counter restarts on every frame-clock edge. A half frame is accepted when it has at least 16 (code 0), 20 (code 1) or 24 (codes 2 to 4) bit slots. A frame with a half one slot shorter than that is dropped, and no strobe is raised for it.
- R10: After reset all outputs are zero and the strobe is low. The partial half frame seen before the first frame-clock edge is never published.
- R11: Any half-frame length from the format minimum up to 32 bit slots gives correct words. Lengths may differ between the left and right halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Bit clock, already synchronized to clk |
| fsyncIn | input | 1 | Frame (channel) clock, already synchronized to clk |
| sdataIn | input | LINES (3) | Serial data, one bit per line |
| fmtSel | input | 3 | Framing code 0 to 4 |
| leftOut | output | LINES x WORD_W (72) | Left words, line n in bits [24n+23:24n] |
| rightOut | output | LINES x WORD_W (72) | Right words, same packing |
| frameValid | output | 1 | One-cycle strobe when a new frame is published |

## Verification
The hardest case to reach is an I2S frame at the minimum ratio. There the LSB of each word crosses into the first slot of the next half frame, so the word is only complete once the opposite channel has begun. The stimulus carries that trailing bit forward from one half to the next, then finishes each run with a short flushing half so the last frame is published. Right-justified padding slots are filled with random bits. Half lengths are drawn at random between the format minimum and 32 slots. Separate directed frames sit exactly on the acceptance threshold and one slot below it, on either half.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'd0,
    FMT_RJ20  = 3'd1,
    FMT_LJ24  = 3'd2,
    FMT_I2S24 = 3'd3,
    FMT_RJ24  = 3'd4
  } fmt_e;

  // strobes from control to datapath, valid for one clk
  typedef struct packed {
    logic shiftEn;      // shift the sampled data bit into every line
    logic captureLeft;  // a valid left half just ended
    logic publish;      // a valid right half ended after a valid left half
  } strobes_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       fsyncIn,
  input  logic [2:0] fmtSel,
  output strobes_t   strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic sclkPrev, lrDly, effLrPrev, seen, synced, leftOk;
  logic [CNT_W-1:0] bitCnt;

  fmt_e fmt;
  logic isI2s, isRj, rise, effLr, lrEdge, halfOk, endedLeft, leftLevel;
  logic [CNT_W-1:0] slotNext, minHalf;

  assign fmt       = fmt_e'(fmtSel);
  assign isI2s     = (fmt == FMT_I2S24);
  assign isRj      = (fmt == FMT_RJ16) || (fmt == FMT_RJ20) || (fmt == FMT_RJ24);
  assign leftLevel = ~isI2s;

  always_comb begin
    case (fmt)
      FMT_RJ16: minHalf = CNT_W'(16);
      FMT_RJ20: minHalf = CNT_W'(20);
      default:  minHalf = CNT_W'(24);
    endcase
  end

  // I2S is handled as left-justified on a frame clock delayed by one bit
  assign rise      = sclkIn & ~sclkPrev;
  assign effLr     = isI2s ? lrDly : fsyncIn;
  assign lrEdge    = rise && seen && (effLr != effLrPrev);
  assign slotNext  = lrEdge ? '0 : ((bitCnt == CNT_MAX) ? bitCnt : bitCnt + 1'b1);
  assign halfOk    = synced && (bitCnt >= minHalf - 1'b1);
  assign endedLeft = (effLrPrev == leftLevel);

  always_comb begin
    strobes.shiftEn     = rise && (isRj || (slotNext < WORD_CNT));
    strobes.captureLeft = lrEdge && halfOk && endedLeft;
    strobes.publish     = lrEdge && halfOk && !endedLeft && leftOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      lrDly     <= 1'b0;
      effLrPrev <= 1'b0;
      seen      <= 1'b0;
      synced    <= 1'b0;
      leftOk    <= 1'b0;
      bitCnt    <= '0;
    end else begin
      sclkPrev <= sclkIn;
      if (rise) begin
        lrDly     <= fsyncIn;
        effLrPrev <= effLr;
        seen      <= 1'b1;
        bitCnt    <= slotNext;
        if (lrEdge) begin
          synced <= 1'b1;
          leftOk <= endedLeft && halfOk;
        end
      end
    end
  end

  assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    lrEdge |=> (bitCnt == '0));

  assert_left_arms_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureLeft |=> leftOk);

  assert_publish_disarms_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.publish |=> !leftOk);

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int LINES  = 3,
  parameter int WORD_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LINES-1:0]              sdataIn,
  input  logic [2:0]                    fmtSel,
  input  strobes_t                      strobes,
  output logic [LINES-1:0][WORD_W-1:0]  leftOut,
  output logic [LINES-1:0][WORD_W-1:0]  rightOut,
  output logic                          frameValid
);

  // shorter words move to the top with zero LSBs
  function automatic logic [WORD_W-1:0] alignWord(input logic [2:0] f,
                                                  input logic [WORD_W-1:0] sh);
    case (fmt_e'(f))
      FMT_RJ16: return {sh[15:0], {(WORD_W-16){1'b0}}};
      FMT_RJ20: return {sh[19:0], {(WORD_W-20){1'b0}}};
      default:  return sh;
    endcase
  endfunction

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    logic [WORD_W-1:0] shiftReg, leftHold, leftQ, rightQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
        leftHold <= '0;
        leftQ    <= '0;
        rightQ   <= '0;
      end else begin
        if (strobes.shiftEn)     shiftReg <= {shiftReg[WORD_W-2:0], sdataIn[ln]};
        if (strobes.captureLeft) leftHold <= alignWord(fmtSel, shiftReg);
        if (strobes.publish) begin
          leftQ  <= leftHold;
          rightQ <= alignWord(fmtSel, shiftReg);
        end
      end
    end

    assign leftOut[ln]  = leftQ;
    assign rightOut[ln] = rightQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameValid <= 1'b0;
    else       frameValid <= strobes.publish;
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> ($stable(leftOut) && $stable(rightOut)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int LINES  = 3,
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclkIn,
  input  logic                          fsyncIn,
  input  logic [LINES-1:0]              sdataIn,
  input  logic [2:0]                    fmtSel,
  output logic [LINES-1:0][WORD_W-1:0]  leftOut,
  output logic [LINES-1:0][WORD_W-1:0]  rightOut,
  output logic                          frameValid
);

  strobes_t strobes;

  sar_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .fsyncIn (fsyncIn),
    .fmtSel  (fmtSel),
    .strobes (strobes)
  );

  sar_datapath #(.LINES(LINES), .WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdataIn    (sdataIn),
    .fmtSel     (fmtSel),
    .strobes    (strobes),
    .leftOut    (leftOut),
    .rightOut   (rightOut),
    .frameValid (frameValid)
  );

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  localparam int LINES = 3;
  typedef logic [LINES-1:0][23:0] words_t;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b1, fsync = 1'b1;
  logic [LINES-1:0] sdata = '0;
  logic [2:0] fmt = 3'd2;
  words_t leftOut, rightOut;
  logic frameValid;

  int checks = 0, fails = 0;
  bit finished = 0;
  string curTag = "R10";
  words_t qL[$], qR[$];
  logic [LINES-1:0] carry = '0;

  always #2.5 clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .fsyncIn(fsync), .sdataIn(sdata),
    .fmtSel(fmt), .leftOut(leftOut), .rightOut(rightOut), .frameValid(frameValid)
  );

  function automatic int wBits(input logic [2:0] f);
    return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
  endfunction

  function automatic bit isRj(input logic [2:0] f);
    return (f == 3'd0) || (f == 3'd1) || (f == 3'd4);
  endfunction

  function automatic logic [23:0] expWord(input logic [2:0] f, input logic [23:0] w);
    if (f == 3'd0) return {w[15:0], 8'h00};
    if (f == 3'd1) return {w[19:0], 4'h0};
    return w;
  endfunction

  // bit on effective slot s of an n-slot half
  function automatic logic effBit(input logic [2:0] f, input int s, input int n,
                                  input logic [23:0] w);
    int k;
    if (isRj(f)) begin
      k = n - 1 - s;
      if (k < wBits(f)) return w[k];
      return logic'($urandom % 2);
    end
    if (s < 24) return w[23-s];
    return logic'($urandom % 2);
  endfunction

  task automatic sendBit(input logic lr, input logic [LINES-1:0] d);
    @(negedge clk);
    sclk = 1'b0; fsync = lr; sdata = d;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendHalf(input logic [2:0] f, input logic lr, input int n,
                          input words_t w);
    logic [LINES-1:0] d;
    for (int s = 0; s < n; s++) begin
      for (int l = 0; l < LINES; l++) begin
        if (f == 3'd3) d[l] = (s == 0) ? carry[l] : effBit(f, s - 1, n, w[l]);
        else           d[l] = effBit(f, s, n, w[l]);
      end
      sendBit(lr, d);
    end
    if (f == 3'd3)
      for (int l = 0; l < LINES; l++) carry[l] = effBit(f, n - 1, n, w[l]);
  endtask

  function automatic words_t randWords(input logic [2:0] f);
    words_t w;
    for (int l = 0; l < LINES; l++)
      w[l] = 24'($urandom) & ((24'h1 << wBits(f)) - 24'h1 | ((wBits(f) == 24) ? 24'hFFFFFF : 24'h0));
    return w;
  endfunction

  task automatic sendFrame(input logic [2:0] f, input int nL, input int nR,
                           input words_t wl, input words_t wr, input bit expectOut);
    logic leftLvl;
    words_t el, er;
    leftLvl = (f == 3'd3) ? 1'b0 : 1'b1;
    sendHalf(f, leftLvl, nL, wl);
    sendHalf(f, ~leftLvl, nR, wr);
    if (expectOut) begin
      for (int l = 0; l < LINES; l++) begin
        el[l] = expWord(f, wl[l]);
        er[l] = expWord(f, wr[l]);
      end
      qL.push_back(el);
      qR.push_back(er);
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic startRun(input logic [2:0] f);
    @(negedge clk);
    rstN = 1'b0; fmt = f; carry = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: partial right half before any frame-clock edge, never published
    for (int i = 0; i < 5; i++) sendBit((f == 3'd3) ? 1'b1 : 1'b0, LINES'($urandom));
  endtask

  task automatic endRun(input logic [2:0] f);
    words_t z;
    z = '0;
    sendHalf(f, (f == 3'd3) ? 1'b0 : 1'b1, 4, z);
    repeat (10) @(negedge clk);
    // R8: every expected frame produced exactly one strobe
    check(qL.size() == 0, curTag, "frames still pending", 24'(qL.size()), 24'd0);
    qL.delete(); qR.delete();
  endtask

  // monitor: compare every published frame with the oldest expected one
  always @(negedge clk) begin
    if (rstN && frameValid && !finished) begin
      if (qL.size() == 0) begin
        check(1'b0, curTag, "unexpected frame strobe (R8/R9/R10)", 24'd1, 24'd0);
      end else begin
        words_t el, er;
        el = qL.pop_front();
        er = qR.pop_front();
        for (int l = 0; l < LINES; l++) begin
          check(leftOut[l] == el[l], curTag, $sformatf("left line%0d", l), leftOut[l], el[l]);
          check(rightOut[l] == er[l], curTag, $sformatf("right line%0d", l), rightOut[l], er[l]);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    words_t wl, wr;
    int nL, nR, mn;
    void'($urandom(32'd20240611));

    // R10: reset state
    repeat (4) @(negedge clk);
    check(frameValid == 1'b0, "R10", "strobe in reset", 24'(frameValid), 24'd0);
    for (int l = 0; l < LINES; l++) begin
      check(leftOut[l] == '0, "R10", "left in reset", leftOut[l], 24'd0);
      check(rightOut[l] == '0, "R10", "right in reset", rightOut[l], 24'd0);
    end

    // random frames per format: R1 R2 R3 R4 R5, R6 random pad, R7 polarity, R11 lengths
    for (int f = 0; f < 5; f++) begin
      case (f)
        0: curTag = "R1/R6/R7/R11";
        1: curTag = "R2/R6/R7/R11";
        2: curTag = "R3/R7/R11";
        3: curTag = "R4/R11";
        default: curTag = "R5/R6/R7/R11";
      endcase
      startRun(3'(f));
      mn = wBits(3'(f));
      for (int i = 0; i < 8; i++) begin
        nL = mn + int'($urandom % (33 - mn));
        nR = mn + int'($urandom % (33 - mn));
        sendFrame(3'(f), nL, nR, randWords(3'(f)), randWords(3'(f)), 1'b1);
      end
      endRun(3'(f));
    end

    // R9: thresholds in 24-bit left-justified
    curTag = "R9";
    startRun(3'd2);
    sendFrame(3'd2, 23, 24, randWords(3'd2), randWords(3'd2), 1'b0);
    sendFrame(3'd2, 24, 24, randWords(3'd2), randWords(3'd2), 1'b1);
    sendFrame(3'd2, 24, 23, randWords(3'd2), randWords(3'd2), 1'b0);
    sendFrame(3'd2, 24, 24, randWords(3'd2), randWords(3'd2), 1'b1);
    endRun(3'd2);

    // R9: thresholds in 16-bit right-justified
    curTag = "R9/R1";
    startRun(3'd0);
    sendFrame(3'd0, 16, 15, randWords(3'd0), randWords(3'd0), 1'b0);
    sendFrame(3'd0, 16, 16, randWords(3'd0), randWords(3'd0), 1'b1);
    sendFrame(3'd0, 15, 16, randWords(3'd0), randWords(3'd0), 1'b0);
    endRun(3'd0);

    // R4: I2S at minimum length, LSB in the first slot of the next half
    curTag = "R4/R9";
    startRun(3'd3);
    for (int i = 0; i < 3; i++) sendFrame(3'd3, 24, 24, randWords(3'd3), randWords(3'd3), 1'b1);
    sendFrame(3'd3, 23, 24, randWords(3'd3), randWords(3'd3), 1'b0);
    sendFrame(3'd3, 24, 24, 24'hFFFFFF, 24'h800001, 1'b1);
    endRun(3'd3);

    // R3: 16-bit word padded with zero LSBs in left-justified framing
    curTag = "R3";
    startRun(3'd2);
    for (int l = 0; l < LINES; l++) begin
      wl[l] = {16'($urandom), 8'h00};
      wr[l] = {16'($urandom), 8'h00};
    end
    sendFrame(3'd2, 32, 32, wl, wr, 1'b1);
    endRun(3'd2);

    finished = 1;
    summary();
  end

endmodule